// File: doc/BRIEF.md
# Backplane Frame Sync Unit

This block keeps track of where the transmit serial stream is inside a T1 or E1 frame, one serial-clock period per bit. It holds a bit counter that wraps at the frame length: 193 clocks for base-rate T1, and 256 for base-rate E1 and for both high-speed multiplexed formats. From that counter it reports the bit position, the timeslot index, and a flag for timeslots that carry no data.

When base rate is selected and the sync direction is set to output, the block drives a one-clock sync pulse on the first bit of every frame. In input mode the block does not drive the sync pin. Input mode applies when the direction is set to input, and always in the two high-speed formats. In this mode the block samples an external sync on the serial clock, with no synchronizer stage. It uses the rising edge of that sync to realign its counter.

In the high-speed formats the sync pulse spans the frame boundary. The 4-clock format covers the last two bits of one frame and the first two bits of the next. The 2-clock format covers the last bit of one frame and the first bit of the next. A rising edge that arrives at an unexpected bit position sets a sticky misalignment flag, and software clears that flag. When T1 traffic is carried in the 256-bit high-speed frame, every fourth timeslot is flagged as don't-care.

Top module: `fsync_top`

## Requirements
- R1: While `rstN` is low, and on the first clock after it rises, `bitPos` reads 0 and `misalign` reads 0.
- R2: With no realignment, `bitPos` counts up by one on each clock and wraps to 0 after `FRAME-1`. FRAME is 193 in mode 0 (T1 base rate) and 256 in modes 1 (E1 base rate), 2 (4-clock high-speed) and 3 (2-clock high-speed).
- R3: In mode 0 or mode 1 with `syncDirIn`=0, `syncOe` is 1. `syncOut` is 1 exactly during the clock in which `bitPos` is 0, which gives one pulse per frame.
- R4: When `syncDirIn`=1, or when mode is 2 or 3 (whatever `syncDirIn` is), both `syncOe` and `syncOut` are 0.
- R5: In base-rate input mode, the clock period in which `syncIn` is first sampled high after being low is taken as bit 0, so `bitPos` reads 1 on the next clock.
- R6: In mode 2, the first high sample of `syncIn` is taken as bit 254. `bitPos` then reads 255 on the next clock and 0 on the clock after that.
- R7: In mode 3, the first high sample of `syncIn` is taken as bit 255, so `bitPos` reads 0 on the next clock.
- R8: In input mode, a rising edge of `syncIn` sampled when `bitPos` differs from the expected position (0, 254 or 255, by mode) sets `misalign` on the next clock. A rising edge at the expected position leaves `misalign` unchanged. `misalign` stays set until `clearMisalign` is sampled high, and a new mismatch in that same clock keeps it set.
- R9: `slotIdx` always equals `bitPos` divided by 8, rounded down.
- R10: `dontCare` is 1 exactly when the mode is 2 or 3, `t1Map` is 1, and `slotIdx` modulo 4 equals 3. In modes 0 and 1 it is always 0.
- R11: Only the low-to-high transition of `syncIn` realigns the counter. Clocks in which `syncIn` stays high leave the count advancing normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 0 T1 base, 1 E1 base, 2 high-speed 4-clock sync, 3 high-speed 2-clock sync |
| syncDirIn | input | 1 | Base rate only: 1 selects external sync input, 0 selects generated sync |
| t1Map | input | 1 | T1 carried in a 256-bit high-speed frame |
| syncIn | input | 1 | External frame sync, synchronous to clk |
| clearMisalign | input | 1 | Clears the sticky misalignment flag |
| syncOut | output | 1 | Generated frame sync pulse |
| syncOe | output | 1 | Output enable for the sync pin |
| bitPos | output | 9 | Current bit position in the frame |
| slotIdx | output | 6 | Current timeslot index |
| dontCare | output | 1 | Current timeslot carries no data |
| misalign | output | 1 | Sticky flag: sync arrived off the expected boundary |

## Verification
A corrupt bit counter shows up on `bitPos` and `slotIdx` on the next clock. In output mode it also moves the `syncOut` pulse, which then goes missing or appears at the wrong place within one frame. A wrong realignment target in a high-speed mode puts every later boundary off by a fixed number of bits. That shows on `bitPos` the clock after the sync edge, and it sets `misalign` when the next correctly placed sync arrives. A lost sync-history bit makes a held sync pulse look like a fresh edge on each of its clocks, which restarts the count instead of letting it advance.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  localparam int CNT_W = 9;
  localparam int SLOT_SHIFT = 3;

  typedef enum logic [1:0] {
    MODE_T1  = 2'd0,
    MODE_E1  = 2'd1,
    MODE_HS4 = 2'd2,
    MODE_HS2 = 2'd3
  } fsMode_e;

  typedef struct packed {
    logic             realign;
    logic             mismatch;
    logic [CNT_W-1:0] loadVal;
  } fsStrobe_t;
endpackage

// File: rtl/fsync_ctrl.sv
module fsync_ctrl
  import fsync_pkg::*;
#(
  parameter int E1_LEN = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  fsMode_e          mode,
  input  logic             syncDirIn,
  input  logic             syncIn,
  input  logic [CNT_W-1:0] bitPos,
  output fsStrobe_t        strobe,
  output logic             inputMode
);
  localparam logic [CNT_W-1:0] HS4_EXPECT = CNT_W'(E1_LEN - 2);
  localparam logic [CNT_W-1:0] HS2_EXPECT = CNT_W'(E1_LEN - 1);

  logic syncPrev;
  logic syncEdge;
  logic [CNT_W-1:0] expectPos;
  logic [CNT_W-1:0] loadVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPrev <= 1'b0;
    else       syncPrev <= syncIn;
  end

  assign inputMode = (mode == MODE_HS4) || (mode == MODE_HS2) || syncDirIn;
  assign syncEdge  = inputMode && syncIn && !syncPrev;

  always_comb begin
    unique case (mode)
      MODE_HS4: begin expectPos = HS4_EXPECT; loadVal = HS2_EXPECT; end
      MODE_HS2: begin expectPos = HS2_EXPECT; loadVal = '0; end
      default:  begin expectPos = '0;         loadVal = CNT_W'(1); end
    endcase
  end

  always_comb begin
    strobe.realign  = syncEdge;
    strobe.mismatch = syncEdge && (bitPos != expectPos);
    strobe.loadVal  = loadVal;
  end

  // R11: a held sync never yields two edges in a row
  a_r11_single_edge: assert property (@(posedge clk) disable iff (!rstN)
    strobe.realign |=> !strobe.realign);

  // R8: a mismatch is only ever reported together with a realignment
  a_r8_mismatch_edge: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mismatch |-> strobe.realign);
endmodule

// File: rtl/fsync_dp.sv
module fsync_dp
  import fsync_pkg::*;
#(
  parameter int T1_LEN = 193,
  parameter int E1_LEN = 256
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  fsMode_e                     mode,
  input  logic                        t1Map,
  input  logic                        clearMisalign,
  input  logic                        inputMode,
  input  fsStrobe_t                   strobe,
  output logic [CNT_W-1:0]            bitPos,
  output logic [CNT_W-SLOT_SHIFT-1:0] slotIdx,
  output logic                        dontCare,
  output logic                        misalign,
  output logic                        syncOut,
  output logic                        syncOe
);
  localparam logic [CNT_W-1:0] T1_LAST = CNT_W'(T1_LEN - 1);
  localparam logic [CNT_W-1:0] E1_LAST = CNT_W'(E1_LEN - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastBit;
  logic             hsMode;

  assign lastBit = (mode == MODE_T1) ? T1_LAST : E1_LAST;
  assign hsMode  = (mode == MODE_HS4) || (mode == MODE_HS2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (strobe.realign)  cnt <= strobe.loadVal;
    else if (cnt >= lastBit)  cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                misalign <= 1'b0;
    else if (strobe.mismatch) misalign <= 1'b1;
    else if (clearMisalign)   misalign <= 1'b0;
  end

  assign bitPos   = cnt;
  assign slotIdx  = cnt[CNT_W-1:SLOT_SHIFT];
  assign dontCare = hsMode && t1Map && (slotIdx[1:0] == 2'b11);
  assign syncOe   = !inputMode;
  assign syncOut  = !inputMode && (cnt == '0);

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.realign && cnt == lastBit) |=> (cnt == '0));

  a_r3_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    syncOut |=> !syncOut);

  a_r4_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    !syncOe |-> !syncOut);

  a_r6_realign_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.realign |=> (cnt == $past(strobe.loadVal)));

  a_r8_set: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mismatch |=> misalign);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (misalign && !clearMisalign) |=> misalign);

  a_r10_dc_mode: assert property (@(posedge clk) disable iff (!rstN)
    dontCare |-> (hsMode && t1Map));
endmodule

// File: rtl/fsync_top.sv
module fsync_top
  import fsync_pkg::*;
#(
  parameter int T1_LEN = 193,
  parameter int E1_LEN = 256
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [1:0]                  mode,
  input  logic                        syncDirIn,
  input  logic                        t1Map,
  input  logic                        syncIn,
  input  logic                        clearMisalign,
  output logic                        syncOut,
  output logic                        syncOe,
  output logic [CNT_W-1:0]            bitPos,
  output logic [CNT_W-SLOT_SHIFT-1:0] slotIdx,
  output logic                        dontCare,
  output logic                        misalign
);
  fsMode_e   modeSel;
  fsStrobe_t strobe;
  logic      inputMode;

  assign modeSel = fsMode_e'(mode);

  fsync_ctrl #(.E1_LEN(E1_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .mode(modeSel), .syncDirIn(syncDirIn),
    .syncIn(syncIn), .bitPos(bitPos), .strobe(strobe), .inputMode(inputMode)
  );

  fsync_dp #(.T1_LEN(T1_LEN), .E1_LEN(E1_LEN)) dp_i (
    .clk(clk), .rstN(rstN), .mode(modeSel), .t1Map(t1Map),
    .clearMisalign(clearMisalign), .inputMode(inputMode), .strobe(strobe),
    .bitPos(bitPos), .slotIdx(slotIdx), .dontCare(dontCare),
    .misalign(misalign), .syncOut(syncOut), .syncOe(syncOe)
  );
endmodule

// File: tb/fsync_top_tb_top.sv
module fsync_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       syncDirIn = 1'b0;
  logic       t1Map = 1'b0;
  logic       syncIn = 1'b0;
  logic       clearMisalign = 1'b0;
  logic       syncOut, syncOe, dontCare, misalign;
  logic [8:0] bitPos;
  logic [5:0] slotIdx;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsync_top dut_i (
    .clk(clk), .rstN(rstN), .mode(mode), .syncDirIn(syncDirIn), .t1Map(t1Map),
    .syncIn(syncIn), .clearMisalign(clearMisalign), .syncOut(syncOut),
    .syncOe(syncOe), .bitPos(bitPos), .slotIdx(slotIdx), .dontCare(dontCare),
    .misalign(misalign)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic resetWith(input logic [1:0] m, input logic dir, input logic map);
    @(negedge clk);
    rstN = 1'b0; mode = m; syncDirIn = dir; t1Map = map;
    syncIn = 1'b0; clearMisalign = 1'b0;
    step(2);
    chk(bitPos == 0, "R1 bitPos in reset", bitPos, 0);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    resetWith(2'd0, 1'b0, 1'b0);
    chk(bitPos == 0, "R1 bitPos after reset", bitPos, 0);
    chk(misalign == 0, "R1 misalign after reset", misalign, 0);
    chk(syncOut == 1, "R3 pulse at bit 0", syncOut, 1);
    chk(syncOe == 1, "R3 output enable", syncOe, 1);
  endtask

  task automatic testT1Out();
    int highs = 0;
    resetWith(2'd0, 1'b0, 1'b0);
    for (int i = 1; i <= 193; i++) begin
      step(1);
      highs += syncOut;
      if (i == 192) chk(bitPos == 192, "R2 T1 last bit", bitPos, 192);
    end
    chk(bitPos == 0, "R2 T1 wrap", bitPos, 0);
    chk(highs == 1, "R3 one pulse per T1 frame", highs, 1);
  endtask

  task automatic testE1Out();
    resetWith(2'd1, 1'b0, 1'b0);
    step(255);
    chk(bitPos == 255, "R2 E1 last bit", bitPos, 255);
    chk(syncOut == 0, "R3 no pulse mid frame", syncOut, 0);
    step(1);
    chk(bitPos == 0, "R2 E1 wrap", bitPos, 0);
    chk(syncOut == 1, "R3 E1 pulse", syncOut, 1);
  endtask

  task automatic testBaseIn();
    resetWith(2'd0, 1'b1, 1'b0);
    chk(syncOe == 0, "R4 base input oe", syncOe, 0);
    chk(syncOut == 0, "R4 base input out", syncOut, 0);
    step(40);
    syncIn = 1'b1; step(1); syncIn = 1'b0;
    chk(bitPos == 1, "R5 realign to bit 1", bitPos, 1);
    chk(misalign == 1, "R8 off-boundary sync", misalign, 1);
    step(5);
    chk(misalign == 1, "R8 sticky", misalign, 1);
    clearMisalign = 1'b1; step(1); clearMisalign = 1'b0;
    chk(misalign == 0, "R8 cleared", misalign, 0);
    step(193 - 7);
    chk(bitPos == 0, "R2 T1 input wrap", bitPos, 0);
    syncIn = 1'b1; step(1); syncIn = 1'b0;
    chk(bitPos == 1, "R5 aligned sync", bitPos, 1);
    chk(misalign == 0, "R8 aligned sync keeps clear", misalign, 0);
    step(3);
    syncIn = 1'b1; clearMisalign = 1'b1; step(1);
    syncIn = 1'b0; clearMisalign = 1'b0;
    chk(misalign == 1, "R8 mismatch beats clear", misalign, 1);
    chk(bitPos == 1, "R5 realign again", bitPos, 1);
  endtask

  task automatic testHs4();
    resetWith(2'd2, 1'b0, 1'b0);
    chk(syncOe == 0, "R4 hs4 forced input", syncOe, 0);
    step(10);
    syncIn = 1'b1; step(1);
    chk(bitPos == 255, "R6 first high is bit 254", bitPos, 255);
    chk(misalign == 1, "R8 hs4 off boundary", misalign, 1);
    step(1);
    chk(bitPos == 0, "R6 boundary", bitPos, 0);
    step(2); syncIn = 1'b0;
    chk(bitPos == 2, "R11 held sync no realign", bitPos, 2);
    clearMisalign = 1'b1; step(1); clearMisalign = 1'b0;
    step(251);
    chk(bitPos == 254, "R2 hs4 count", bitPos, 254);
    syncIn = 1'b1; step(4); syncIn = 1'b0;
    chk(bitPos == 2, "R6 aligned pulse", bitPos, 2);
    chk(misalign == 0, "R8 hs4 aligned", misalign, 0);
  endtask

  task automatic testHs2();
    resetWith(2'd3, 1'b0, 1'b0);
    chk(syncOut == 0, "R4 hs2 no out", syncOut, 0);
    step(20);
    syncIn = 1'b1; step(1);
    chk(bitPos == 0, "R7 first high is bit 255", bitPos, 0);
    chk(misalign == 1, "R8 hs2 off boundary", misalign, 1);
    step(1); syncIn = 1'b0;
    chk(bitPos == 1, "R11 hs2 second high", bitPos, 1);
    clearMisalign = 1'b1; step(1); clearMisalign = 1'b0;
    step(253);
    chk(bitPos == 255, "R2 hs2 count", bitPos, 255);
    syncIn = 1'b1; step(2); syncIn = 1'b0;
    chk(bitPos == 1, "R7 aligned pulse", bitPos, 1);
    chk(misalign == 0, "R8 hs2 aligned", misalign, 0);
  endtask

  task automatic testSlots();
    resetWith(2'd2, 1'b0, 1'b1);
    for (int i = 0; i < 256; i++) begin
      chk(slotIdx == (bitPos >> 3), "R9 slot index", slotIdx, bitPos >> 3);
      chk(dontCare == (((bitPos >> 3) % 4) == 3), "R10 dont-care slot",
          dontCare, (((bitPos >> 3) % 4) == 3));
      chk(syncOut == 0, "R4 hs4 out low", syncOut, 0);
      step(1);
    end
    resetWith(2'd1, 1'b0, 1'b1);
    for (int i = 0; i < 64; i++) begin
      chk(dontCare == 0, "R10 base mode never dont-care", dontCare, 0);
      step(1);
    end
    resetWith(2'd3, 1'b0, 1'b0);
    for (int i = 0; i < 64; i++) begin
      chk(dontCare == 0, "R10 map off never dont-care", dontCare, 0);
      step(1);
    end
  endtask

  initial begin
    testReset();
    testT1Out();
    testE1Out();
    testBaseIn();
    testHs4();
    testHs2();
    testSlots();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule